// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight level-sensitive interrupt requests and raises one interrupt line toward a processor. When the processor acknowledges, the block hands back an 8-bit vector that names the winning input. Input 0 has the highest priority and input 7 the lowest. The block keeps three 8-bit registers. The request register samples the inputs. The in-service register records what the processor is currently handling. The mask register blocks selected inputs.

Software reaches the block through a byte-wide port with two addresses. Address 0 is the command address and address 1 is the data address. A command byte with bit 4 set restarts programming. The next data bytes then set, in a fixed order, the vector base, the cascade word and the mode word. Once programming is complete, command bytes end service routines and choose which register a command-address read returns. Data bytes load the mask.

Top module: `intc_top`

## Requirements
- R1: After reset, `int_out` is 0, `vec_out` is 0x00, a data-address read returns 0xFF (all inputs masked), and a command-address read returns the request register.
- R2: A command write with bit 4 set starts programming. It clears the mask and in-service registers, turns auto-EOI off and selects the request register for command-address reads. `int_out` stays 0 and `ack` is ignored until the last programming byte has been taken.
- R3: The first data write after the start byte sets the vector base. A granted acknowledge returns base + n for input n, clears request bit n for that cycle and sets in-service bit n. `vec_out` changes on the clock edge that samples `ack`.
- R4: Each request is sampled into the request register one clock after it appears. `int_out` is 1 when the lowest-numbered unmasked request has a lower index than every set in-service bit.
- R5: Outside programming, a data write loads the mask, and a 1 in bit n blocks input n. A data read returns the mask.
- R6: The command byte 0x20 clears the lowest-numbered set in-service bit.
- R7: The command byte 0x60 + n (n = 0..7) clears in-service bit n only.
- R8: The command bytes 0x0A, 0x0B and 0x09 make later command-address reads return, respectively, the request register, the in-service register and the stored cascade word. The choice holds until another such byte is written.
- R9: When bit 1 of the mode word is 1 (auto-EOI), a granted acknowledge returns the vector and leaves the in-service register unchanged.
- R10: An acknowledge while `int_out` is 0 returns base + 7 and sets no in-service bit.
- R11: Bit 1 of the start byte (single mode) skips the cascade word and leaves the stored cascade word as it was. Bit 0 of the start byte at 0 skips the mode word, and the block then runs with normal EOI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_in | input | 8 | Level interrupt requests, bit 0 highest |
| int_out | output | 1 | Interrupt request toward the processor |
| ack | input | 1 | One-cycle acknowledge pulse |
| vec_out | output | 8 | Vector of the last acknowledge |

## Verification
The assertions check the following on every cycle:
- An in-service bit is set only by a granted acknowledge.
- Auto-EOI and spurious acknowledges add no in-service bit.
- A spurious acknowledge returns base + 7.
- The interrupt line stays quiet while programming is in progress.
- A start byte empties the in-service register.

Only the bench's scenarios can show the rest:
- The programming order, including the skipped cascade and mode words.
- Priority among nested requests.
- Which bit each EOI form clears.
- Read-back selection and its persistence.
- The exact vectors returned for each base.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NUM_IN = 8;
    localparam int IDX_W  = $clog2(NUM_IN);
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} seq_t;
    typedef enum logic [1:0] {RD_REQ, RD_SVC, RD_CASC} rdsel_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic pick_t first_set(logic [NUM_IN-1:0] v);
        pick_t r;
        r = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [NUM_IN-1:0] onehot(logic [IDX_W-1:0] idx);
        return NUM_IN'(1) << idx;
    endfunction

endpackage

// File: rtl/pic_prio.sv
module pic_prio
    import pic_pkg::*;
(
    input  logic [NUM_IN-1:0] req_q,
    input  logic [NUM_IN-1:0] mask_q,
    input  logic [NUM_IN-1:0] svc_q,
    input  logic              enable,
    output logic              int_req,
    output pick_t             win,
    output pick_t             svc_top
);
    always_comb begin
        win     = first_set(req_q & ~mask_q);
        svc_top = first_set(svc_q);
        int_req = enable && win.valid && (!svc_top.valid || (win.idx < svc_top.idx));
    end
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              running,
    output logic              start_wr,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] casc_q,
    output logic              auto_q,
    output logic [NUM_IN-1:0] mask_q,
    output rdsel_t            rdsel_q,
    output logic              eoi_top,
    output logic              eoi_one,
    output logic [IDX_W-1:0]  eoi_lvl
);
    seq_t state_q;
    logic single_q, need_mode_q;
    logic cmd_wr, dat_wr, op_wr, sel_wr, eoi_wr;

    always_comb begin
        cmd_wr   = wr_en && !addr;
        dat_wr   = wr_en && addr;
        start_wr = cmd_wr && wdata[4];
        op_wr    = cmd_wr && !wdata[4] && (state_q == ST_RUN);
        sel_wr   = op_wr && wdata[3];
        eoi_wr   = op_wr && !wdata[3];
        eoi_top  = eoi_wr && (wdata[7:5] == 3'b001);
        eoi_one  = eoi_wr && (wdata[7:5] == 3'b011);
        eoi_lvl  = wdata[IDX_W-1:0];
        running  = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_RUN;
            base_q      <= '0;
            casc_q      <= '0;
            auto_q      <= 1'b0;
            mask_q      <= '1;
            rdsel_q     <= RD_REQ;
            single_q    <= 1'b0;
            need_mode_q <= 1'b0;
        end else if (start_wr) begin
            state_q     <= ST_BASE;
            mask_q      <= '0;
            auto_q      <= 1'b0;
            rdsel_q     <= RD_REQ;
            single_q    <= wdata[1];
            need_mode_q <= wdata[0];
        end else begin
            if (sel_wr) begin
                case (wdata[1:0])
                    2'b10:   rdsel_q <= RD_REQ;
                    2'b11:   rdsel_q <= RD_SVC;
                    2'b01:   rdsel_q <= RD_CASC;
                    default: rdsel_q <= rdsel_q;
                endcase
            end
            if (dat_wr) begin
                case (state_q)
                    ST_BASE: begin
                        base_q <= wdata;
                        if (!single_q)        state_q <= ST_CASC;
                        else if (need_mode_q) state_q <= ST_MODE;
                        else                  state_q <= ST_RUN;
                    end
                    ST_CASC: begin
                        casc_q  <= wdata;
                        state_q <= need_mode_q ? ST_MODE : ST_RUN;
                    end
                    ST_MODE: begin
                        auto_q  <= wdata[1];
                        state_q <= ST_RUN;
                    end
                    default: mask_q <= wdata;
                endcase
            end
        end
    end

    // R5: a data write while running lands in the mask
    a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && running && !start_wr) |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/pic_svc.sv
module pic_svc
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              ack_ok,
    input  logic              int_req,
    input  pick_t             win,
    input  pick_t             svc_top,
    input  logic              auto_q,
    input  logic [DATA_W-1:0] base_q,
    input  logic              start_wr,
    input  logic              eoi_top,
    input  logic              eoi_one,
    input  logic [IDX_W-1:0]  eoi_lvl,
    output logic [NUM_IN-1:0] req_q,
    output logic [NUM_IN-1:0] svc_q,
    output logic [DATA_W-1:0] vec_q
);
    localparam logic [DATA_W-1:0] LAST_IDX = DATA_W'(NUM_IN - 1);

    logic              grant;
    logic [NUM_IN-1:0] take, clr;

    always_comb begin
        grant = ack_ok && int_req;
        take  = grant ? onehot(win.idx) : '0;
        clr   = '0;
        if (eoi_top && svc_top.valid) clr = onehot(svc_top.idx);
        if (eoi_one)                  clr = onehot(eoi_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            svc_q <= '0;
            vec_q <= '0;
        end else begin
            req_q <= irq_in & ~take;
            if (start_wr) svc_q <= '0;
            else          svc_q <= (svc_q | (auto_q ? '0 : take)) & ~clr;
            if (ack_ok)
                vec_q <= grant ? (base_q + DATA_W'(win.idx)) : (base_q + LAST_IDX);
        end
    end

    // R3: in-service bits appear only after a granted acknowledge
    a_r3_svc_needs_grant: assert property (@(posedge clk) disable iff (rst)
        !grant |=> ((svc_q & ~$past(svc_q)) == '0));
    // R9: auto-EOI acknowledge adds nothing to in-service
    a_r9_auto_no_svc: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && auto_q) |=> ((svc_q & ~$past(svc_q)) == '0));
    // R10: spurious acknowledge returns the lowest-priority vector
    a_r10_spurious_vec: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && !int_req) |=> (vec_q == $past(base_q) + LAST_IDX));
endmodule

// File: rtl/intc_top.sv
module intc_top
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              int_out,
    input  logic              ack,
    output logic [DATA_W-1:0] vec_out
);
    logic              running, start_wr, auto_q, eoi_top, eoi_one, int_req;
    logic [DATA_W-1:0] base_q, casc_q;
    logic [NUM_IN-1:0] mask_q, req_q, svc_q;
    logic [IDX_W-1:0]  eoi_lvl;
    rdsel_t            rdsel_q;
    pick_t             win, svc_top;

    pic_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .running(running), .start_wr(start_wr), .base_q(base_q), .casc_q(casc_q),
        .auto_q(auto_q), .mask_q(mask_q), .rdsel_q(rdsel_q),
        .eoi_top(eoi_top), .eoi_one(eoi_one), .eoi_lvl(eoi_lvl)
    );

    pic_prio u_prio (
        .req_q(req_q), .mask_q(mask_q), .svc_q(svc_q), .enable(running),
        .int_req(int_req), .win(win), .svc_top(svc_top)
    );

    pic_svc u_svc (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack_ok(ack && running),
        .int_req(int_req), .win(win), .svc_top(svc_top), .auto_q(auto_q),
        .base_q(base_q), .start_wr(start_wr), .eoi_top(eoi_top), .eoi_one(eoi_one),
        .eoi_lvl(eoi_lvl), .req_q(req_q), .svc_q(svc_q), .vec_q(vec_out)
    );

    assign int_out = int_req;

    always_comb begin
        if (addr) rdata = mask_q;
        else begin
            case (rdsel_q)
                RD_SVC:  rdata = svc_q;
                RD_CASC: rdata = casc_q;
                default: rdata = req_q;
            endcase
        end
    end

    // R2: no interrupt while programming is in progress
    a_r2_quiet_in_setup: assert property (@(posedge clk) disable iff (rst)
        !running |-> !int_out);
    // R2: a start byte empties the in-service register
    a_r2_start_clears_svc: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> (svc_q == '0));
endmodule

// File: tb/intc_top_tb.sv
`timescale 1ns/1ps
module intc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = 8'h00, irq_in = 8'h00;
    logic [7:0] rdata, vec_out;
    logic       int_out;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intc_top dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .ack(ack), .vec_out(vec_out));

    // behavioural reference model
    int         m_state, m_sel;
    logic [7:0] m_irr, m_isr, m_imr, m_base, m_cas, m_vec;
    bit         m_auto, m_single, m_need;

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit m_int();
        return (m_state == 0) && (lowest(m_irr & ~m_imr) < lowest(m_isr));
    endfunction

    always @(posedge clk) begin
        logic [7:0] n_irr, n_isr;
        int w, s;
        if (rst) begin
            m_state = 0; m_sel = 0; m_irr = 0; m_isr = 0; m_imr = 8'hFF;
            m_base = 0; m_cas = 0; m_vec = 0; m_auto = 0; m_single = 0; m_need = 0;
        end else begin
            w = lowest(m_irr & ~m_imr);
            s = lowest(m_isr);
            n_irr = irq_in;
            n_isr = m_isr;
            if (ack && m_state == 0) begin
                if (m_int()) begin
                    m_vec = m_base + 8'(w);
                    n_irr[w] = 1'b0;
                    if (!m_auto) n_isr[w] = 1'b1;
                end else m_vec = m_base + 8'd7;
            end
            if (wr_en && !addr) begin
                if (wdata[4]) begin
                    m_state = 2; m_imr = 0; n_isr = 0; m_sel = 0; m_auto = 0;
                    m_single = wdata[1]; m_need = wdata[0];
                end else if (m_state == 0) begin
                    if (wdata[3]) begin
                        if (wdata[1:0] == 2'b10) m_sel = 0;
                        else if (wdata[1:0] == 2'b11) m_sel = 1;
                        else if (wdata[1:0] == 2'b01) m_sel = 2;
                    end else if (wdata[7:5] == 3'b001) begin
                        if (s < 8) n_isr[s] = 1'b0;
                    end else if (wdata[7:5] == 3'b011) n_isr[wdata[2:0]] = 1'b0;
                end
            end
            if (wr_en && addr) begin
                case (m_state)
                    2: begin m_base = wdata; m_state = !m_single ? 3 : (m_need ? 4 : 0); end
                    3: begin m_cas = wdata; m_state = m_need ? 4 : 0; end
                    4: begin m_auto = wdata[1]; m_state = 0; end
                    default: m_imr = wdata;
                endcase
            end
            m_irr = n_irr;
            m_isr = n_isr;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("MODEL int_out", {7'd0, int_out}, {7'd0, m_int()});
            check("MODEL vec_out", vec_out, m_vec);
            check("MODEL rdata", rdata,
                  addr ? m_imr : (m_sel == 1 ? m_isr : (m_sel == 2 ? m_cas : m_irr)));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask
    task automatic wr(logic a, logic [7:0] d);
        @(posedge clk); #1; wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask
    task automatic rd(logic a, logic [7:0] exp, string tag);
        @(posedge clk); #1; addr = a;
        @(negedge clk); check(tag, rdata, exp);
    endtask
    task automatic do_ack(logic [7:0] exp, string tag);
        @(posedge clk); #1; ack = 1'b1;
        @(posedge clk); #1; ack = 1'b0;
        @(negedge clk); check(tag, vec_out, exp);
    endtask
    task automatic set_irq(logic [7:0] v);
        @(posedge clk); #1; irq_in = v; idle(2);
    endtask
    task automatic chk_int(logic e, string tag);
        @(negedge clk); check(tag, {7'd0, int_out}, {7'd0, e});
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(4); rst = 1'b0;
        chk_int(1'b0, "R1 int_out after reset");
        check("R1 vec_out after reset", vec_out, 8'h00);
        rd(1'b1, 8'hFF, "R1 mask after reset");
        rd(1'b0, 8'h00, "R1 request read after reset");
        // program: base 0x08, cascade 0x04, normal EOI
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h11);
        rd(1'b1, 8'h00, "R2 start clears mask");
        set_irq(8'h01);
        chk_int(1'b0, "R2 quiet during programming");
        do_ack(8'h00, "R2 ack ignored during programming");
        wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        chk_int(1'b1, "R4 request after programming");
        wr(1'b1, 8'hFF);
        chk_int(1'b0, "R5 masked input");
        rd(1'b1, 8'hFF, "R5 mask read");
        wr(1'b1, 8'h00);
        set_irq(8'h24);
        chk_int(1'b1, "R4 pending");
        do_ack(8'h0A, "R3 vector base+2");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h04, "R8 in-service read");
        chk_int(1'b0, "R4 lower request blocked by in-service");
        set_irq(8'h25);
        chk_int(1'b1, "R4 higher request nests");
        do_ack(8'h08, "R3 vector base+0");
        rd(1'b0, 8'h05, "R3 two in service");
        wr(1'b0, 8'h62);
        rd(1'b0, 8'h01, "R7 specific EOI clears bit 2 only");
        chk_int(1'b0, "R4 nothing beats input 0");
        wr(1'b0, 8'h20);
        rd(1'b0, 8'h00, "R6 non-specific EOI");
        set_irq(8'h00);
        chk_int(1'b0, "R10 no request");
        do_ack(8'h0F, "R10 spurious vector");
        rd(1'b0, 8'h00, "R10 no in-service bit");
        wr(1'b0, 8'h0A);
        set_irq(8'h81);
        rd(1'b0, 8'h81, "R8 request read");
        wr(1'b0, 8'h09);
        rd(1'b0, 8'h04, "R8 cascade read");
        idle(3);
        rd(1'b0, 8'h04, "R8 selection persists");
        wr(1'b1, 8'h01);
        do_ack(8'h0F, "R5 masked input 0 skipped");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h80, "R5 input 7 in service");
        wr(1'b0, 8'h20);
        // single mode with auto-EOI, base 0x20
        set_irq(8'h00);
        wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h03);
        wr(1'b0, 8'h09);
        rd(1'b0, 8'h04, "R11 cascade word kept");
        set_irq(8'h10);
        do_ack(8'h24, "R9 vector base+4");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R9 auto-EOI leaves in-service clear");
        idle(1);
        chk_int(1'b1, "R9 request still served");
        // single mode without mode word
        wr(1'b0, 8'h12); wr(1'b1, 8'h40);
        wr(1'b1, 8'hF0);
        rd(1'b1, 8'hF0, "R11 next data write is mask");
        set_irq(8'h12);
        do_ack(8'h41, "R11 vector base+1");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h02, "R11 normal EOI mode");
        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule